// File: doc/BRIEF.md
# Descriptor-Chained Frame Writer

This block is a bus-master write engine that places formatted preview frames into memory. The destination of each frame comes from a small record held in memory. The record is two 32-bit words: the buffer address comes first, and the address of the following record comes second. The engine fetches one record when a frame starts. It streams that frame's pixel words out of a first-word-fall-through FIFO into the buffer the record names. When the frame has been written, the engine moves on to the record that the second word points at.

Software writes the address of the first record into a head pointer and sets the enable input. A ring of records with the last one pointing back to the first gives ping-pong buffering or N-buffer rotation, and no software action is needed per frame. Pixel words go out in fixed-length bursts whenever the FIFO fill level reaches a threshold. After the frame-end event, whatever is left below the threshold goes out as one shorter burst. A one-cycle pulse marks the completion of each frame.

The memory port is a plain request/grant port:

- The engine holds the request, write flag, start address and beat count steady until it sees the grant.
- Read beats come back on a valid strobe.
- Write beats are presented one per cycle and are accepted without stalls.
- The slave advances its own beat address by 4 bytes per beat.

Top module: `fbc_dma`

## Requirements
- R1: While reset is held and in the first cycle after it, `mem_req`, `mem_wvalid`, `fifo_pop` and `frame_done` are all low.
- R2: A frame-start event, seen while enabled and idle, makes the engine issue a read request before any write. The read has length 2 and is addressed to the current record. Read beat 0 is taken as the buffer address and read beat 1 as the next-record address.
- R3: A frame's pixel words are written as 32-bit beats in FIFO order. The first beat goes to the buffer address from the record, and each later beat lands 4 bytes above the previous one, across all bursts of the frame.
- R4: Whenever the FIFO level is at least THRESH, the engine requests a write burst of exactly THRESH beats. Every write burst has between 1 and THRESH beats. Request, address and length stay stable until granted.
- R5: After the frame-end event, a nonzero remainder below THRESH is written as one final burst of that many beats. When the remainder is zero, no extra burst is issued.
- R6: Each frame after the first uses the record whose address was read as word 1 of the previous record. A ring of three records sends frames to buffers 0, 1, 2 and then 0 again.
- R7: `frame_done` pulses high for exactly one cycle, once per frame, after the last write beat of that frame. No request or write beat is active in that cycle.
- R8: Clearing `en` during a frame lets that frame complete, with its data written and `frame_done` pulsed. A frame-start event while `en` is low issues no memory request.
- R9: When `en` is set again after being low while idle, the next frame fetches its record from `head_ptr`, not from the saved next-record address.
- R10: A frame-start event that arrives while a frame is in progress is ignored: no second record fetch takes place for that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Engine enable |
| head_ptr | input | AW | Address of the first record in the chain |
| frame_sof | input | 1 | Frame-start event, one cycle |
| frame_eof | input | 1 | Frame-end event, one cycle |
| fifo_level | input | LW | Words currently held in the pixel FIFO |
| fifo_data | input | 32 | Head word of the pixel FIFO |
| fifo_pop | output | 1 | Removes the head word from the FIFO |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write (1) or a read (0) |
| mem_addr | output | AW | Byte address of the burst start |
| mem_len | output | LW | Burst length in beats |
| mem_gnt | input | 1 | Request accepted |
| mem_wvalid | output | 1 | Write beat valid |
| mem_wdata | output | 32 | Write beat data |
| mem_rvalid | input | 1 | Read beat valid |
| mem_rdata | input | 32 | Read beat data |
| frame_done | output | 1 | One-cycle frame completion pulse |

## Verification
The bench targets these corner cases:

- **Ring wrap.** A fourth frame sent to a three-record ring must land in buffer 0 again. A design that kept a stale next pointer would overwrite the wrong buffer.
- **Remainder sizes.** Frames of 3, 9, 13, 4 and 8 words exercise the remainder logic, including exact multiples of the threshold. A design that always padded to THRESH, or that skipped the tail, would show a wrong burst count, a wrong final length or a missing word.
- **Enable handling.** `en` is dropped mid-frame, and a start pulse is then sent while disabled. After that, the head pointer is moved to a different chain and `en` is re-enabled. A design that stopped abruptly, reacted to the disabled start, or resumed from the old chain would be caught.
- **Late start pulse.** A second start pulse inside a busy frame must not cause a second record fetch.

// File: rtl/fbc_pkg.sv
`timescale 1ns/1ps
package fbc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DREQ,
    ST_DRD,
    ST_RUN,
    ST_WREQ,
    ST_WBEAT
  } fbc_state_e;

  localparam int unsigned BEAT_BYTES = 4;
  localparam int unsigned DESC_WORDS = 2;
endpackage

// File: rtl/fbc_desc.sv
`timescale 1ns/1ps
// Record pointer tracking: chooses the fetch address and splits the two read beats.
module fbc_desc #(
  parameter int unsigned AW = 32,
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          idle,
  input  logic [AW-1:0] head_ptr,
  input  logic          fetch_go,
  input  logic          rd_beat,
  input  logic [DW-1:0] rd_data,
  output logic [AW-1:0] fetch_addr,
  output logic          dest_load,
  output logic          desc_done
);
  logic          fresh;
  logic          rd_idx;
  logic [AW-1:0] next_ptr;

  always_ff @(posedge clk) begin
    if (rst) begin
      fresh    <= 1'b1;
      rd_idx   <= 1'b0;
      next_ptr <= '0;
    end else begin
      if (idle && !en) begin
        fresh <= 1'b1;
      end else if (fetch_go) begin
        fresh <= 1'b0;
      end
      if (fetch_go) begin
        rd_idx <= 1'b0;
      end else if (rd_beat) begin
        rd_idx <= ~rd_idx;
        if (rd_idx) begin
          next_ptr <= rd_data[AW-1:0];
        end
      end
    end
  end

  assign fetch_addr = fresh ? head_ptr : next_ptr;
  assign dest_load  = rd_beat && !rd_idx;
  assign desc_done  = rd_beat && rd_idx;
endmodule

// File: rtl/fbc_beat.sv
`timescale 1ns/1ps
// Write address and per-burst beat counting.
module fbc_beat #(
  parameter int unsigned AW = 32,
  parameter int unsigned LW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          base_load,
  input  logic [AW-1:0] base_val,
  input  logic          burst_load,
  input  logic [LW-1:0] burst_len,
  input  logic          beat,
  output logic [AW-1:0] wr_addr,
  output logic          last_beat
);
  import fbc_pkg::*;
  localparam logic [AW-1:0] STEP = AW'(BEAT_BYTES);

  logic [LW-1:0] left;

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_addr <= '0;
      left    <= '0;
    end else begin
      if (base_load) begin
        wr_addr <= base_val;
      end else if (beat) begin
        wr_addr <= wr_addr + STEP;
      end
      if (burst_load) begin
        left <= burst_len;
      end else if (beat && left != '0) begin
        left <= left - 1'b1;
      end
    end
  end

  assign last_beat = (left == LW'(1));
endmodule

// File: rtl/fbc_ctrl.sv
`timescale 1ns/1ps
// Frame sequencing: record fetch, threshold bursts, remainder drain, completion.
module fbc_ctrl #(
  parameter int unsigned AW     = 32,
  parameter int unsigned LW     = 8,
  parameter int unsigned THRESH = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          sof,
  input  logic          eof,
  input  logic [LW-1:0] level,
  input  logic          mem_gnt,
  input  logic          desc_done,
  input  logic [AW-1:0] fetch_addr,
  input  logic [AW-1:0] wr_addr,
  input  logic          last_beat,
  output logic          idle,
  output logic          fetch_go,
  output logic          rd_phase,
  output logic          burst_load,
  output logic          beat,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [LW-1:0] mem_len,
  output logic          frame_done
);
  import fbc_pkg::*;
  localparam logic [LW-1:0] THR  = LW'(THRESH);
  localparam logic [LW-1:0] DLEN = LW'(DESC_WORDS);

  fbc_state_e st;
  logic       eof_seen;

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_IDLE;
      mem_req    <= 1'b0;
      mem_we     <= 1'b0;
      mem_addr   <= '0;
      mem_len    <= '0;
      frame_done <= 1'b0;
      eof_seen   <= 1'b0;
    end else begin
      frame_done <= 1'b0;
      if (st != ST_IDLE && eof) begin
        eof_seen <= 1'b1;
      end
      case (st)
        ST_IDLE: begin
          eof_seen <= 1'b0;
          if (en && sof) begin
            mem_req  <= 1'b1;
            mem_we   <= 1'b0;
            mem_addr <= fetch_addr;
            mem_len  <= DLEN;
            st       <= ST_DREQ;
          end
        end
        ST_DREQ: begin
          if (mem_gnt) begin
            mem_req <= 1'b0;
            st      <= ST_DRD;
          end
        end
        ST_DRD: begin
          if (desc_done) begin
            st <= ST_RUN;
          end
        end
        ST_RUN: begin
          if (level >= THR) begin
            mem_req  <= 1'b1;
            mem_we   <= 1'b1;
            mem_addr <= wr_addr;
            mem_len  <= THR;
            st       <= ST_WREQ;
          end else if (eof_seen || eof) begin
            if (level != '0) begin
              mem_req  <= 1'b1;
              mem_we   <= 1'b1;
              mem_addr <= wr_addr;
              mem_len  <= level;
              st       <= ST_WREQ;
            end else begin
              frame_done <= 1'b1;
              st         <= ST_IDLE;
            end
          end
        end
        ST_WREQ: begin
          if (mem_gnt) begin
            mem_req <= 1'b0;
            st      <= ST_WBEAT;
          end
        end
        ST_WBEAT: begin
          if (last_beat) begin
            st <= ST_RUN;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign idle       = (st == ST_IDLE);
  assign fetch_go   = idle && en && sof;
  assign rd_phase   = (st == ST_DRD);
  assign burst_load = (st == ST_WREQ) && mem_gnt;
  assign beat       = (st == ST_WBEAT);
endmodule

// File: rtl/fbc_dma.sv
`timescale 1ns/1ps
module fbc_dma #(
  parameter int unsigned AW     = 32,
  parameter int unsigned LW     = 8,
  parameter int unsigned THRESH = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic [AW-1:0] head_ptr,
  input  logic          frame_sof,
  input  logic          frame_eof,
  input  logic [LW-1:0] fifo_level,
  input  logic [31:0]   fifo_data,
  output logic          fifo_pop,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [LW-1:0] mem_len,
  input  logic          mem_gnt,
  output logic          mem_wvalid,
  output logic [31:0]   mem_wdata,
  input  logic          mem_rvalid,
  input  logic [31:0]   mem_rdata,
  output logic          frame_done
);
  localparam int unsigned DW = 32;

  logic          idle, fetch_go, rd_phase, burst_load, beat;
  logic          dest_load, desc_done, last_beat;
  logic [AW-1:0] fetch_addr, wr_addr;

  fbc_ctrl #(.AW(AW), .LW(LW), .THRESH(THRESH)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .en         (en),
    .sof        (frame_sof),
    .eof        (frame_eof),
    .level      (fifo_level),
    .mem_gnt    (mem_gnt),
    .desc_done  (desc_done),
    .fetch_addr (fetch_addr),
    .wr_addr    (wr_addr),
    .last_beat  (last_beat),
    .idle       (idle),
    .fetch_go   (fetch_go),
    .rd_phase   (rd_phase),
    .burst_load (burst_load),
    .beat       (beat),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_len    (mem_len),
    .frame_done (frame_done)
  );

  fbc_desc #(.AW(AW), .DW(DW)) u_desc (
    .clk        (clk),
    .rst        (rst),
    .en         (en),
    .idle       (idle),
    .head_ptr   (head_ptr),
    .fetch_go   (fetch_go),
    .rd_beat    (mem_rvalid && rd_phase),
    .rd_data    (mem_rdata),
    .fetch_addr (fetch_addr),
    .dest_load  (dest_load),
    .desc_done  (desc_done)
  );

  fbc_beat #(.AW(AW), .LW(LW)) u_beat (
    .clk        (clk),
    .rst        (rst),
    .base_load  (dest_load),
    .base_val   (mem_rdata[AW-1:0]),
    .burst_load (burst_load),
    .burst_len  (mem_len),
    .beat       (beat),
    .wr_addr    (wr_addr),
    .last_beat  (last_beat)
  );

  assign mem_wvalid = beat;
  assign fifo_pop   = beat;
  assign mem_wdata  = fifo_data;
endmodule

// File: rtl/fbc_dma_chk.sv
`timescale 1ns/1ps
module fbc_dma_chk #(
  parameter int unsigned AW     = 32,
  parameter int unsigned LW     = 8,
  parameter int unsigned THRESH = 4
) (
  input logic          clk,
  input logic          rst,
  input logic [LW-1:0] fifo_level,
  input logic          fifo_pop,
  input logic          mem_req,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic [LW-1:0] mem_len,
  input logic          mem_gnt,
  input logic          mem_wvalid,
  input logic          frame_done
);
  a_r2_desc_two_beats: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_we) |-> (mem_len == LW'(2)));

  a_r4_burst_len: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_we) |-> (mem_len != '0 && mem_len <= LW'(THRESH)));

  a_r4_req_hold: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr) && $stable(mem_len) && $stable(mem_we)));

  a_r3_pop_has_data: assert property (@(posedge clk) disable iff (rst)
    fifo_pop |-> (fifo_level != '0));

  a_r3_beat_no_req: assert property (@(posedge clk) disable iff (rst)
    mem_wvalid |-> !mem_req);

  a_r7_done_single: assert property (@(posedge clk) disable iff (rst)
    frame_done |=> !frame_done);

  a_r7_done_quiet: assert property (@(posedge clk) disable iff (rst)
    frame_done |-> (!mem_req && !mem_wvalid));
endmodule

bind fbc_dma fbc_dma_chk #(.AW(AW), .LW(LW), .THRESH(THRESH)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .fifo_level (fifo_level),
  .fifo_pop   (fifo_pop),
  .mem_req    (mem_req),
  .mem_we     (mem_we),
  .mem_addr   (mem_addr),
  .mem_len    (mem_len),
  .mem_gnt    (mem_gnt),
  .mem_wvalid (mem_wvalid),
  .frame_done (frame_done)
);

// File: tb/fbc_dma_bench.sv
`timescale 1ns/1ps
module fbc_dma_bench;
  localparam int AW = 32;
  localparam int LW = 8;
  localparam int TH = 4;
  localparam int NV = 5;
  // stimulus table: words per frame, extra start pulse mid-frame
  localparam int FR_N [NV] = '{9, 8, 3, 4, 13};
  localparam bit FR_X [NV] = '{1'b0, 1'b0, 1'b1, 1'b0, 1'b0};

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          rst = 1'b1;
  logic          en = 1'b0;
  logic [AW-1:0] head_ptr = 32'h100;
  logic          frame_sof = 1'b0, frame_eof = 1'b0;
  logic [LW-1:0] fifo_level;
  logic [31:0]   fifo_data;
  logic          fifo_pop, mem_req, mem_we, mem_wvalid, frame_done;
  logic [AW-1:0] mem_addr;
  logic [LW-1:0] mem_len;
  logic          mem_gnt, mem_rvalid;
  logic [31:0]   mem_wdata, mem_rdata;

  fbc_dma #(.AW(AW), .LW(LW), .THRESH(TH)) u_fbc_dma (
    .clk(clk), .rst(rst), .en(en), .head_ptr(head_ptr),
    .frame_sof(frame_sof), .frame_eof(frame_eof),
    .fifo_level(fifo_level), .fifo_data(fifo_data), .fifo_pop(fifo_pop),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_len(mem_len),
    .mem_gnt(mem_gnt), .mem_wvalid(mem_wvalid), .mem_wdata(mem_wdata),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .frame_done(frame_done)
  );

  // pixel FIFO model
  logic [31:0] fq [0:255];
  logic [7:0]  fwp, frp;
  logic        push_en = 1'b0;
  logic [31:0] push_val = '0;
  always @(posedge clk) begin
    if (rst) begin
      fwp <= '0; frp <= '0;
    end else begin
      if (push_en) begin fq[fwp] <= push_val; fwp <= fwp + 1'b1; end
      if (fifo_pop) frp <= frp + 1'b1;
    end
  end
  assign fifo_level = fwp - frp;
  assign fifo_data  = fq[frp];

  // memory slave model, holds record chains and buffers
  logic [31:0] mem [0:1023];
  logic [31:0] sl_addr;
  int          rd_left;
  always @(posedge clk) begin
    mem_gnt <= 1'b0;
    if (rst) begin
      mem_rvalid <= 1'b0; rd_left <= 0; sl_addr <= '0; mem_rdata <= '0;
      for (int i = 0; i < 1024; i++) mem[i] <= '0;
      mem[32'h100 >> 2] <= 32'h200; mem[32'h104 >> 2] <= 32'h108;
      mem[32'h108 >> 2] <= 32'h400; mem[32'h10C >> 2] <= 32'h110;
      mem[32'h110 >> 2] <= 32'h600; mem[32'h114 >> 2] <= 32'h100;
      mem[32'h180 >> 2] <= 32'h800; mem[32'h184 >> 2] <= 32'h180;
    end else begin
      if (rd_left > 0) begin
        mem_rvalid <= 1'b1; mem_rdata <= mem[sl_addr[11:2]];
        sl_addr <= sl_addr + 4; rd_left <= rd_left - 1;
      end else begin
        mem_rvalid <= 1'b0;
      end
      if (mem_wvalid) begin
        mem[sl_addr[11:2]] <= mem_wdata; sl_addr <= sl_addr + 4;
      end
      if (mem_req && !mem_gnt) begin
        mem_gnt <= 1'b1; sl_addr <= mem_addr;
        if (!mem_we) rd_left <= int'(mem_len);
      end
    end
  end

  // grant log and completion count
  bit          log_we   [0:255];
  logic [31:0] log_addr [0:255];
  int          log_len  [0:255];
  int          gcount = 0, done_cnt = 0;
  always @(posedge clk) begin
    if (!rst && mem_req && mem_gnt) begin
      log_we[gcount[7:0]] <= mem_we; log_addr[gcount[7:0]] <= mem_addr;
      log_len[gcount[7:0]] <= int'(mem_len); gcount <= gcount + 1;
    end
    if (!rst && frame_done) done_cnt <= done_cnt + 1;
  end

  int checks = 0, errors = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic run_frame(input int n, input bit xsof, input bit drop_en,
                           input logic [31:0] exp_desc, input logic [31:0] exp_dest,
                           input logic [31:0] base);
    int g0 = gcount, d0 = done_cnt, t = 0, rd = 0, wb = 0, ll = 0, bad = 0;
    logic [31:0] bad_act = '0, bad_exp = '0;
    @(negedge clk) frame_sof = 1'b1;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      frame_sof = (xsof && i == 1);
      if (drop_en && i == 0) en = 1'b0;
      push_en = 1'b1; push_val = base + i;
    end
    @(negedge clk) push_en = 1'b0; frame_sof = 1'b0; frame_eof = 1'b1;
    @(negedge clk) frame_eof = 1'b0;
    while (done_cnt == d0 && t < 2000) begin @(negedge clk); t++; end
    repeat (10) @(negedge clk);
    for (int g = g0; g < gcount; g++) begin
      if (!log_we[g[7:0]]) rd++; else begin wb++; ll = log_len[g[7:0]]; end
    end
    for (int i = 0; i < n; i++) begin
      if (mem[(exp_dest >> 2) + i] !== base + i && bad == 0) begin
        bad_act = mem[(exp_dest >> 2) + i]; bad_exp = base + i;
      end
      if (mem[(exp_dest >> 2) + i] !== base + i) bad++;
    end
    check(!log_we[g0[7:0]] && log_addr[g0[7:0]] == exp_desc, "R2", "first request read of record",
          log_addr[g0[7:0]], exp_desc);
    check(rd == 1, "R10", "record fetches per frame", rd, 1);
    check(bad == 0, "R3/R6", "buffer contents", bad_act, bad_exp);
    check(wb == n / TH + ((n % TH) != 0 ? 1 : 0), "R4", "write burst count", wb,
          n / TH + ((n % TH) != 0 ? 1 : 0));
    check(ll == ((n % TH) != 0 ? n % TH : TH), "R5", "final burst length", ll,
          (n % TH) != 0 ? n % TH : TH);
    check(done_cnt - d0 == 1, "R7", "completion pulses", done_cnt - d0, 1);
  endtask

  initial begin
    int g0, d0;
    repeat (3) @(negedge clk);
    check(!mem_req && !mem_wvalid && !fifo_pop && !frame_done, "R1", "outputs in reset",
          {mem_req, mem_wvalid, fifo_pop, frame_done}, 0);
    rst = 1'b0; en = 1'b1;
    @(negedge clk);
    check(!mem_req && !frame_done, "R1", "outputs after reset", {mem_req, frame_done}, 0);
    // table walk over a three-record ring (R6 wrap at vector 3)
    for (int k = 0; k < NV; k++) begin
      run_frame(FR_N[k], FR_X[k], 1'b0, 32'h100 + 8 * (k % 3), 32'h200 * ((k % 3) + 1),
                32'h1000 * (k + 1));
    end
    // R8: enable cleared mid-frame, frame still finishes into buffer 2
    run_frame(6, 1'b0, 1'b1, 32'h110, 32'h600, 32'h7000);
    g0 = gcount; d0 = done_cnt;
    @(negedge clk) frame_sof = 1'b1;
    @(negedge clk) frame_sof = 1'b0;
    repeat (20) @(negedge clk);
    check(gcount == g0, "R8", "requests after start while disabled", gcount - g0, 0);
    check(done_cnt == d0, "R8", "completions while disabled", done_cnt - d0, 0);
    // R9: new head pointer, re-enable, record taken from head
    head_ptr = 32'h180; en = 1'b1;
    run_frame(5, 1'b0, 1'b0, 32'h180, 32'h800, 32'h8000);
    run_frame(4, 1'b0, 1'b0, 32'h180, 32'h800, 32'h9000);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule